// File: doc/BRIEF.md
# Sleep-mode bus wake detector

This block sits beside a LIN transceiver's low-power bus comparator and decides when a sleeping node should wake. The comparator bit is high while the bus voltage is below the wake threshold. The detector needs two things in order. First, the bus must stay low for a parameterised debounce time, measured in microsecond ticks. Second, the bus must then return high. When both have happened, the detector emits a single-cycle wake pulse. The power controller uses that pulse to leave sleep and start the regulator.

The detector only listens while the sleep-active input is high. Whenever sleep is left, all of its state is discarded. It fires at most once per sleep period. It is armed again only when sleep is entered anew.

The block has no data stream, so no valid/ready handshake appears. All pins are plain control and status signals, sampled on the block clock. The comparator bit is asynchronous and is synchronised inside the block. The tick input is a one-cycle enable that pulses once per microsecond. The debounce length `DEBOUNCE_US` must be at least 2.

Top module: `lin_wake_detect`

## Requirements
- R1: `bus_low_raw` passes through a two-flop synchronizer. With the detector armed and the low phase already qualified, `wake_pulse` rises on the third rising clock edge after `bus_low_raw` is driven to 0.
- R2: While `sleep_en` is 0, no wake pulse is produced, whatever the bus does.
- R3: A low phase counts as activity only after `DEBOUNCE_US` tick pulses have been seen while the synchronised bus is low. A low phase with fewer ticks followed by a rise gives no wake.
- R4: If the synchronised bus returns high before the debounce count is reached, the count restarts from zero. Two short low phases never add up.
- R5: A qualified low phase produces a wake only once the bus goes high. `wake_pulse` is high for exactly one clock cycle.
- R6: If the bus is already low when `sleep_en` rises, ticks are counted only from sleep entry onward.
- R7: At most one wake pulse occurs per sleep period. A new wake needs `sleep_en` to fall and rise again.
- R8: Dropping `sleep_en` in the middle of a low phase clears the partial count. Counting restarts from zero when sleep is re-entered.
- R9: While `rst_n` is low, and directly after reset, `wake_pulse` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| us_tick | input | 1 | One-cycle enable, once per microsecond |
| sleep_en | input | 1 | High while the node is in its lowest-power mode |
| bus_low_raw | input | 1 | Asynchronous comparator bit, 1 when the bus is below the wake threshold |
| wake_pulse | output | 1 | One-cycle wake indication |

## Verification
The checker assumes a few things about the inputs. It assumes `sleep_en` is held low during reset, and that `bus_low_raw` holds each level for at least a few clock cycles, so the synchronizer never drops a level. On that basis it checks four properties: every pulse lasts one cycle, every pulse happens inside sleep, every pulse comes after the bus went high, and there is no second pulse in one sleep period. The stimulus changes every input on the falling clock edge. Ticks arrive every fourth cycle. Low-phase lengths stay five ticks clear of the debounce limit on either side, so the one-tick uncertainty at the start of a low phase cannot flip an expected outcome.

// File: rtl/lin_wake_pkg.sv
package lin_wake_pkg;
  typedef enum logic [1:0] {
    WK_IDLE  = 2'd0,
    WK_COUNT = 2'd1,
    WK_QUAL  = 2'd2,
    WK_DONE  = 2'd3
  } wake_state_t;
endpackage

// File: rtl/lin_wake_sync.sv
module lin_wake_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/lin_wake_timer.sv
module lin_wake_timer #(
  parameter int LIMIT = 80
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic tick,
  output logic hit
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (tick)  cnt <= cnt + 1'b1;
  end

  // Last required tick of the low phase arrives now.
  assign hit = !clr && tick && (cnt == LAST);
endmodule

// File: rtl/lin_wake_ctrl.sv
module lin_wake_ctrl
  import lin_wake_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed_in,
  input  logic        low_s,
  input  logic        qual_hit,
  output wake_state_t state,
  output logic        pulse
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= WK_IDLE;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (!armed_in) begin
        state <= WK_IDLE;
      end else begin
        unique case (state)
          WK_IDLE:  state <= WK_COUNT;
          WK_COUNT: if (qual_hit) state <= WK_QUAL;
          WK_QUAL:  if (!low_s) begin
                      state <= WK_DONE;
                      pulse <= 1'b1;
                    end
          WK_DONE:  state <= WK_DONE;
          default:  state <= WK_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/lin_wake_detect.sv
module lin_wake_detect
  import lin_wake_pkg::*;
#(
  parameter int DEBOUNCE_US = 80,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic us_tick,
  input  logic sleep_en,
  input  logic bus_low_raw,
  output logic wake_pulse
);
  logic        low_s;
  logic        qual_hit;
  logic        cnt_clr;
  wake_state_t st;

  lin_wake_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .din(bus_low_raw), .dout(low_s)
  );

  // Count only while armed in the counting state and the bus is low.
  assign cnt_clr = (st != WK_COUNT) || !low_s || !sleep_en;

  lin_wake_timer #(.LIMIT(DEBOUNCE_US)) timer_i (
    .clk(clk), .rst_n(rst_n), .clr(cnt_clr), .tick(us_tick), .hit(qual_hit)
  );

  lin_wake_ctrl ctrl_i (
    .clk(clk), .rst_n(rst_n), .armed_in(sleep_en), .low_s(low_s),
    .qual_hit(qual_hit), .state(st), .pulse(wake_pulse)
  );
endmodule

// File: rtl/lin_wake_detect_chk.sv
module lin_wake_detect_chk (
  input logic clk,
  input logic rst_n,
  input logic sleep_en,
  input logic bus_low_raw,
  input logic wake_pulse
);
  logic fired;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         fired <= 1'b0;
    else if (!sleep_en) fired <= 1'b0;
    else if (wake_pulse) fired <= 1'b1;
  end

  assert_single_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |=> !wake_pulse);

  assert_only_in_sleep_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> $past(sleep_en));

  assert_after_rise_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !$past(bus_low_raw, 3));

  assert_once_per_sleep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wake_pulse |-> !fired);
endmodule

bind lin_wake_detect lin_wake_detect_chk chk_i (
  .clk(clk), .rst_n(rst_n), .sleep_en(sleep_en),
  .bus_low_raw(bus_low_raw), .wake_pulse(wake_pulse)
);

// File: tb/lin_wake_detect_tb_top.sv
`timescale 1ns/1ps
module lin_wake_detect_tb_top;
  localparam int DEB = 80;
  localparam int TICK_DIV = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic us_tick = 1'b0;
  logic sleep_en = 1'b0;
  logic bus_low_raw = 1'b0;
  logic wake_pulse;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int exp_q[$];
  int obs_q[$];
  logic prev_pulse = 1'b0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  lin_wake_detect #(.DEBOUNCE_US(DEB)) dut_i (
    .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .sleep_en(sleep_en),
    .bus_low_raw(bus_low_raw), .wake_pulse(wake_pulse)
  );

  always @(posedge clk) cyc <= cyc + 1;

  // Tick generator: one pulse every TICK_DIV cycles.
  initial begin
    forever begin
      for (int i = 0; i < TICK_DIV - 1; i++) @(negedge clk);
      us_tick = 1'b1;
      @(negedge clk);
      us_tick = 1'b0;
    end
  end

  // Monitor: records pulses and checks their width (R5).
  always @(negedge clk) begin
    if (rst_n && wake_pulse) obs_q.push_back(cyc);
    if (rst_n && wake_pulse && prev_pulse) begin
      fails++;
      $display("FAIL R5: pulse wider than one cycle at cyc %0d (actual 2+, expected 1)", cyc);
    end
    prev_pulse = wake_pulse;
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // Driver: hold the bus low for a number of ticks, release it, and push the expected pulse cycle.
  task automatic low_then_rise(input int ticks, input bit expect_wake);
    @(negedge clk);
    bus_low_raw = 1'b1;
    idle(ticks * TICK_DIV);
    bus_low_raw = 1'b0;
    if (expect_wake) exp_q.push_back(cyc + 3);
    idle(12);
  endtask

  // Scoreboard compare: pops both queues.
  task automatic compare(input string req);
    checks++;
    if (exp_q.size() != obs_q.size()) begin
      fails++;
      $display("FAIL %s: pulse count actual %0d expected %0d", req, obs_q.size(), exp_q.size());
    end else begin
      while (exp_q.size() > 0) begin
        int e = exp_q.pop_front();
        int o = obs_q.pop_front();
        if (e != o) begin
          fails++;
          $display("FAIL %s: pulse cycle actual %0d expected %0d", req, o, e);
        end
      end
    end
    exp_q.delete();
    obs_q.delete();
  endtask

  task automatic leave_and_enter();
    @(negedge clk);
    sleep_en = 1'b0;
    idle(5);
    sleep_en = 1'b1;
    idle(3);
  endtask

  initial begin
    idle(5);
    checks++;
    if (wake_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R9: wake_pulse in reset actual %b expected 0", wake_pulse);
    end
    rst_n = 1'b1;
    idle(3);
    checks++;
    if (wake_pulse !== 1'b0) begin
      fails++;
      $display("FAIL R9: wake_pulse after reset actual %b expected 0", wake_pulse);
    end

    // R2: long low phase with sleep off gives nothing.
    low_then_rise(DEB + 10, 1'b0);
    compare("R2");

    // R3/R1/R5: qualified low phase then rise gives one pulse, three cycles later.
    sleep_en = 1'b1;
    idle(3);
    low_then_rise(DEB + 5, 1'b1);
    compare("R1");

    // R7: second qualified phase in the same sleep period gives nothing.
    low_then_rise(DEB + 5, 1'b0);
    compare("R7");

    // R7: re-arming via sleep re-entry allows a wake again.
    leave_and_enter();
    low_then_rise(DEB + 5, 1'b1);
    compare("R7");

    // R3: too short.
    leave_and_enter();
    low_then_rise(DEB - 5, 1'b0);
    compare("R3");

    // R4: two short phases separated by a high glitch never add up.
    leave_and_enter();
    low_then_rise(DEB - 20, 1'b0);
    low_then_rise(DEB - 20, 1'b0);
    compare("R4");
    // R4: after the restart a full-length phase still wakes.
    low_then_rise(DEB + 5, 1'b1);
    compare("R4");

    // R5: bus held low far past the limit gives nothing until it rises.
    leave_and_enter();
    @(negedge clk);
    bus_low_raw = 1'b1;
    idle((DEB + 40) * TICK_DIV);
    checks++;
    if (obs_q.size() != 0) begin
      fails++;
      $display("FAIL R5: pulse before rise actual %0d expected 0", obs_q.size());
    end
    bus_low_raw = 1'b0;
    exp_q.push_back(cyc + 3);
    idle(12);
    compare("R5");

    // R6: low before entry counts only from entry (short remainder: no wake).
    @(negedge clk);
    sleep_en = 1'b0;
    bus_low_raw = 1'b1;
    idle(60 * TICK_DIV);
    sleep_en = 1'b1;
    idle(30 * TICK_DIV);
    bus_low_raw = 1'b0;
    idle(12);
    compare("R6");

    // R6: enough ticks after entry -> wake.
    @(negedge clk);
    sleep_en = 1'b0;
    bus_low_raw = 1'b1;
    idle(60 * TICK_DIV);
    sleep_en = 1'b1;
    idle((DEB + 5) * TICK_DIV);
    bus_low_raw = 1'b0;
    exp_q.push_back(cyc + 3);
    idle(12);
    compare("R6");

    // R8: leaving sleep mid-count clears the partial count.
    leave_and_enter();
    @(negedge clk);
    bus_low_raw = 1'b1;
    idle(60 * TICK_DIV);
    sleep_en = 1'b0;
    idle(5);
    sleep_en = 1'b1;
    idle(30 * TICK_DIV);
    bus_low_raw = 1'b0;
    idle(12);
    compare("R8");

    // R2: dropping sleep in the qualified state, then rising, gives nothing.
    @(negedge clk);
    bus_low_raw = 1'b1;
    idle((DEB + 5) * TICK_DIV);
    sleep_en = 1'b0;
    idle(3);
    bus_low_raw = 1'b0;
    idle(12);
    compare("R2");

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog: run hung (actual timeout, expected completion)");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule